// File: doc/BRIEF.md
# ALC Gain Step Scheduler

This block is the timing core of an automatic level control loop wrapped around a programmable input gain stage. It does no gain arithmetic and no level detection. It turns a sample-rate tick and a half-sample tick into single-cycle strobes. A limiter strobe tells the gain datapath to take one step down. A recovery strobe tells it to take one step back up after a quiet interval. A fade strobe tells it to move one step in a requested fade direction.

Three 2-bit period codes select the cadence of each strobe. They are normally driven from a timer-selection register whose reset contents give a limiter code of 00 and recovery and fade codes of 10. A flag from the level detector marks the input as above the threshold. Two request bits ask for a fade-in or a fade-out. A mode bit says that zero-crossing detection is switched off. In that mode each limiter change is applied at once, so a step period as short as half a sample is allowed.

Top module: `alc_step_sched`

## Requirements
- R1: With `zc_off_i` = 1, while `over_i` is high, `lim_step_o` pulses once every 1, 2, 4 or 8 `half_tick_i` ticks for `lim_code_i` = 00, 01, 10 or 11. While `over_i` is low, the limiter counter is cleared and no limiter step is issued.
- R2: With `zc_off_i` = 0, code 00 behaves like code 01 (2 half ticks, one sample), so no limiter period shorter than one sample is used. Codes 01 to 11 are unchanged.
- R3: While `over_i` is low, `rec_step_o` pulses once every 512, 1024, 2048 or 4096 `fs_tick_i` ticks for `wait_code_i` = 00 to 11. The count starts from zero when `over_i` falls.
- R4: While `over_i` is high, the recovery counter is held at zero, so no recovery step follows in the next cycle. A limiter step can only occur in that state, so a limiter event also clears any pending recovery.
- R5: While `fade_in_i` or `fade_out_i` is high, `fade_step_o` pulses once every 512, 1024, 2048 or 4096 `fs_tick_i` ticks for `fade_code_i` = 00 to 11. With neither request, the fade counter is cleared and no fade step is issued.
- R6: `fade_dir_o` is 1 for a fade-out step and 0 for a fade-in step. When both requests are set, fade-out wins.
- R7: Every step output is a registered single-cycle pulse. It is high in the cycle after the clock edge at which the tick completing the period was sampled.
- R8: A change of a period code restarts the matching counter from zero. For the limiter, a change of `zc_off_i` also restarts it.
- R9: While `rst_ni` is low, all outputs are 0 and all counters are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fs_tick_i | input | 1 | One-cycle pulse per sample period |
| half_tick_i | input | 1 | One-cycle pulse per half sample period |
| zc_off_i | input | 1 | Zero-crossing detection disabled |
| lim_code_i | input | 2 | Limiter step period code |
| wait_code_i | input | 2 | Recovery wait period code |
| fade_code_i | input | 2 | Fade step period code |
| over_i | input | 1 | Input level above threshold |
| fade_in_i | input | 1 | Fade-in request |
| fade_out_i | input | 1 | Fade-out request |
| lim_step_o | output | 1 | Limiter step pulse |
| rec_step_o | output | 1 | Recovery step pulse |
| fade_step_o | output | 1 | Fade step pulse |
| fade_dir_o | output | 1 | Fade step direction, 1 = out |

## Verification
The limiter is run at several codes with zero-crossing detection both off and on. The number of steps in a fixed window separates the half-sample period from the one-sample period and shows that code 00 is promoted in the zero-crossing mode. Recovery is run with the level held high, where no steps may appear, and then released, where exact multiples of the wait period must appear. This separates a counter that is held cleared from one that is merely paused. Fade is tried with fade-in only, both requests, and neither request, which pins down the direction priority and the idle state. A behavioural model compares every output on every clock, so a code switched mid-period shows whether the counter restarts.

// File: rtl/alc_sched_pkg.sv
package alc_sched_pkg;
  localparam int CODE_W = 2;
  localparam int MAX_SH = (1 << CODE_W) - 1;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic {
    FADE_IN  = 1'b0,
    FADE_OUT = 1'b1
  } fade_dir_e;
endpackage

// File: rtl/alc_code_watch.sv
module alc_code_watch #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] code_i,
  output logic         chg_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= code_i;
  end

  assign chg_o = (code_i != prev_q);
endmodule

// File: rtl/alc_step_counter.sv
module alc_step_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             step_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else if (!run_i || restart_i) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == last_i) begin
        cnt_q  <= '0;
        step_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        step_q <= 1'b0;
      end
    end else begin
      step_q <= 1'b0;
    end
  end

  assign step_o = step_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !restart_i) |-> (cnt_q <= last_i)); // R8
  AST_STEP_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $past(tick_i && run_i && !restart_i)); // R7
endmodule

// File: rtl/alc_step_sched.sv
module alc_step_sched
  import alc_sched_pkg::*;
#(
  parameter int BASE_LOG2 = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fs_tick_i,
  input  logic        half_tick_i,
  input  logic        zc_off_i,
  input  logic [1:0]  lim_code_i,
  input  logic [1:0]  wait_code_i,
  input  logic [1:0]  fade_code_i,
  input  logic        over_i,
  input  logic        fade_in_i,
  input  logic        fade_out_i,
  output logic        lim_step_o,
  output logic        rec_step_o,
  output logic        fade_step_o,
  output logic        fade_dir_o
);
  localparam int LIM_W = MAX_SH;
  localparam int LONG_W = BASE_LOG2 + MAX_SH;

  code_t            lim_eff;
  logic [LIM_W-1:0] lim_last;
  logic [LONG_W-1:0] rec_last, fade_last;
  logic             lim_chg, rec_chg, fade_chg;
  logic             fade_req;
  fade_dir_e        dir_q;

  // half-sample limiter period only without zero-crossing detection
  always_comb begin
    lim_eff = code_t'(lim_code_i);
    if (!zc_off_i && lim_code_i == '0) lim_eff = code_t'(1);
  end

  assign lim_last  = {LIM_W{1'b1}} >> (code_t'(MAX_SH) - lim_eff);
  assign rec_last  = {LONG_W{1'b1}} >> (code_t'(MAX_SH) - code_t'(wait_code_i));
  assign fade_last = {LONG_W{1'b1}} >> (code_t'(MAX_SH) - code_t'(fade_code_i));
  assign fade_req  = fade_in_i | fade_out_i;

  alc_code_watch #(.W(CODE_W + 1)) u_lim_watch (
    .clk_i, .rst_ni, .code_i({zc_off_i, lim_code_i}), .chg_o(lim_chg));
  alc_code_watch #(.W(CODE_W)) u_rec_watch (
    .clk_i, .rst_ni, .code_i(wait_code_i), .chg_o(rec_chg));
  alc_code_watch #(.W(CODE_W)) u_fade_watch (
    .clk_i, .rst_ni, .code_i(fade_code_i), .chg_o(fade_chg));

  alc_step_counter #(.CNT_W(LIM_W)) u_lim_cnt (
    .clk_i, .rst_ni, .tick_i(half_tick_i), .run_i(over_i),
    .restart_i(lim_chg), .last_i(lim_last), .step_o(lim_step_o));

  // held cleared while above threshold; limiter steps only happen then
  alc_step_counter #(.CNT_W(LONG_W)) u_rec_cnt (
    .clk_i, .rst_ni, .tick_i(fs_tick_i), .run_i(!over_i),
    .restart_i(rec_chg), .last_i(rec_last), .step_o(rec_step_o));

  alc_step_counter #(.CNT_W(LONG_W)) u_fade_cnt (
    .clk_i, .rst_ni, .tick_i(fs_tick_i), .run_i(fade_req),
    .restart_i(fade_chg), .last_i(fade_last), .step_o(fade_step_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dir_q <= FADE_IN;
    else if (fade_out_i) dir_q <= FADE_OUT;
    else                 dir_q <= FADE_IN;
  end

  assign fade_dir_o = dir_q;

  AST_NO_REC_WHEN_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_i |=> !rec_step_o); // R4
  AST_LIM_ONLY_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !over_i |=> !lim_step_o); // R1
  AST_NO_FADE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fade_in_i || fade_out_i) |=> !fade_step_o); // R5
  AST_FADE_OUT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fade_out_i && fade_in_i) |=> fade_dir_o); // R6
endmodule

// File: tb/alc_step_sched_tb.sv
module alc_step_sched_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fs_tick_i = 1'b0, half_tick_i = 1'b0, zc_off_i = 1'b0;
  logic [1:0] lim_code_i = 2'b00, wait_code_i = 2'b10, fade_code_i = 2'b10;
  logic over_i = 1'b0, fade_in_i = 1'b0, fade_out_i = 1'b0;
  logic lim_step_o, rec_step_o, fade_step_o, fade_dir_o;

  int checks = 0, errors = 0;
  int phase = 0;
  bit done = 0;
  int n_lim = 0, n_rec = 0, n_fade = 0, n_dir = 0;

  // reference state
  int lim_n = 0, rec_n = 0, fade_n = 0;
  logic [2:0] p_lim = '0;
  logic [1:0] p_wait = '0, p_fade = '0;
  logic e_lim = 0, e_rec = 0, e_fade = 0, e_dir = 0;

  always #10 clk_i = ~clk_i;

  alc_step_sched u_dut (.*);

  // ticks: half every 2 cycles, fs every 4
  always @(negedge clk_i) begin
    phase++;
    half_tick_i = (phase % 2 == 0);
    fs_tick_i   = (phase % 4 == 0);
  end

  always @(posedge clk_i) begin
    int per;
    if (!rst_ni) begin
      lim_n = 0; rec_n = 0; fade_n = 0;
      e_lim = 0; e_rec = 0; e_fade = 0; e_dir = 0;
    end else begin
      if (lim_step_o) n_lim++;
      if (rec_step_o) n_rec++;
      if (fade_step_o) n_fade++;
      if (fade_step_o && fade_dir_o) n_dir++;
      per = 1 << lim_code_i;
      if (!zc_off_i && lim_code_i == 0) per = 2;
      e_lim = 0;
      if ({zc_off_i, lim_code_i} != p_lim || !over_i) lim_n = 0;
      else if (half_tick_i) begin
        lim_n++;
        if (lim_n == per) begin e_lim = 1; lim_n = 0; end
      end
      e_rec = 0;
      if (wait_code_i != p_wait || over_i) rec_n = 0;
      else if (fs_tick_i) begin
        rec_n++;
        if (rec_n == (512 << wait_code_i)) begin e_rec = 1; rec_n = 0; end
      end
      e_fade = 0;
      if (fade_code_i != p_fade || !(fade_in_i || fade_out_i)) fade_n = 0;
      else if (fs_tick_i) begin
        fade_n++;
        if (fade_n == (512 << fade_code_i)) begin e_fade = 1; fade_n = 0; end
      end
      e_dir = fade_out_i;
    end
    p_lim = {zc_off_i, lim_code_i}; p_wait = wait_code_i; p_fade = fade_code_i;
  end

  always @(negedge clk_i) begin
    checks++;
    if (lim_step_o !== e_lim) begin
      errors++; $display("FAIL R1/R2/R7/R8 lim_step actual %b expected %b t=%0t", lim_step_o, e_lim, $time);
    end
    if (rec_step_o !== e_rec) begin
      errors++; $display("FAIL R3/R4/R7/R8 rec_step actual %b expected %b t=%0t", rec_step_o, e_rec, $time);
    end
    if (fade_step_o !== e_fade) begin
      errors++; $display("FAIL R5/R7/R8 fade_step actual %b expected %b t=%0t", fade_step_o, e_fade, $time);
    end
    if (fade_step_o && fade_dir_o !== e_dir) begin
      errors++; $display("FAIL R6 fade_dir actual %b expected %b t=%0t", fade_dir_o, e_dir, $time);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic clr_counts();
    @(negedge clk_i);
    n_lim = 0; n_rec = 0; n_fade = 0; n_dir = 0;
  endtask

  task automatic expect_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++; $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic lim_window(input string tag, input logic zc, input logic [1:0] c,
                            input int cyc, input int exp);
    over_i = 0; zc_off_i = zc; lim_code_i = c;
    wait_cyc(4);
    clr_counts();
    over_i = 1;
    wait_cyc(cyc);
    over_i = 0;
    wait_cyc(3);
    expect_eq(tag, n_lim, exp);
  endtask

  initial begin
    wait_cyc(3);
    expect_eq("R9 reset lim", int'(lim_step_o), 0);
    expect_eq("R9 reset rec", int'(rec_step_o), 0);
    expect_eq("R9 reset fade", int'(fade_step_o), 0);
    expect_eq("R9 reset dir", int'(fade_dir_o), 0);
    wait_code_i = 2'b00; fade_code_i = 2'b00;
    rst_ni = 1;
    // R1 limiter cadence, zero-crossing off
    lim_window("R1 code00", 1'b1, 2'b00, 40, 20);
    lim_window("R1 code01", 1'b1, 2'b01, 40, 10);
    lim_window("R1 code11", 1'b1, 2'b11, 80, 5);
    // R2 zero-crossing on promotes 00
    lim_window("R2 code00", 1'b0, 2'b00, 40, 10);
    lim_window("R2 code10", 1'b0, 2'b10, 80, 10);
    // R8 code change mid-period, model checks restart
    over_i = 1; zc_off_i = 1; lim_code_i = 2'b11;
    wait_cyc(11);
    lim_code_i = 2'b10;
    wait_cyc(30);
    zc_off_i = 0; lim_code_i = 2'b00;
    wait_cyc(30);
    // R4 held high: no recovery
    clr_counts();
    wait_cyc(3000);
    expect_eq("R4 no recovery while over", n_rec, 0);
    // R3 recovery after release, code 00
    over_i = 0;
    clr_counts();
    wait_cyc(4200);
    expect_eq("R3 recovery code00", n_rec, 2);
    // R4 limiter burst clears pending wait
    over_i = 1; wait_cyc(4); over_i = 0;
    clr_counts();
    wait_cyc(2000);
    expect_eq("R4 wait restarted", n_rec, 0);
    // R8 wait code change restarts
    wait_code_i = 2'b01;
    clr_counts();
    wait_cyc(4150);
    expect_eq("R3 recovery code01", n_rec, 1);
    over_i = 1; wait_cyc(4);
    wait_code_i = 2'b11; over_i = 0;
    clr_counts();
    wait_cyc(16500);
    expect_eq("R3 recovery code11", n_rec, 1);
    over_i = 1;
    // R5 fade-in
    fade_in_i = 1;
    clr_counts();
    wait_cyc(4200);
    expect_eq("R5 fade-in steps", n_fade, 2);
    expect_eq("R6 fade-in dir", n_dir, 0);
    // R6 both requested: out wins
    fade_out_i = 1; fade_code_i = 2'b01;
    clr_counts();
    wait_cyc(4200);
    expect_eq("R5 fade both steps", n_fade, 1);
    expect_eq("R6 fade-out priority", n_dir, 1);
    // R5 idle
    fade_in_i = 0; fade_out_i = 0;
    clr_counts();
    wait_cyc(5000);
    expect_eq("R5 no fade when idle", n_fade, 0);
    // R9 reset mid-run
    fade_in_i = 1; zc_off_i = 1; lim_code_i = 2'b00;
    wait_cyc(20);
    rst_ni = 0;
    #1;
    expect_eq("R9 async reset lim", int'(lim_step_o), 0);
    wait_cyc(3);
    rst_ni = 1;
    wait_cyc(20);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule